// File: doc/BRIEF.md
# Converter Fault Supervisor

This block watches a digitally controlled step-down converter through quantized samples of output voltage, output current and die temperature. Each sample arrives with a valid strobe. From these samples and the live voltage setpoint it decides when the converter must be switched off. It also drives two open-drain lines: a power-good indication and a fault line that several supervisors share in a wired-AND.

Every voltage threshold scales with the setpoint. They are recomputed with fixed-point multiplies whenever the setpoint code changes. An overvoltage trip holds the converter off until the enable input is dropped. Undervoltage, overcurrent and overtemperature trips start a timed restart instead. Restart after an overtemperature trip also waits until the die has cooled below a lower threshold. When another device holds the shared fault line low, this converter is switched off as well, and it resumes once the line is released.

Top module: `conv_fault_supervisor`

## Requirements
- R1: During and after reset, with enable low, conv_off_o is 1, pg_pulldown_o is 1 and flt_pulldown_o is 0.
- R2: Voltage thresholds are (setpoint code × K) >> 10, truncated, with K = 1331 for overvoltage, 768 for undervoltage, 922 for the power-good low limit and 1126 for the power-good high limit. The overvoltage threshold is never below the OV_FLOOR code. A sample trips overvoltage only when vout is strictly above the threshold.
- R3: An overvoltage trip keeps conv_off_o high for as long as en_i stays high, with no timed restart.
- R4: A sample with vout strictly below the undervoltage threshold trips a retry fault. The check is suppressed while vref_ramping_i is high.
- R5: A sample with iout strictly above RATED_I × 140 / 100 trips a retry fault. A sample exactly at that limit does not.
- R6: A sample with temp at or above OT_TRIP trips a retry fault. The restart waits until a later sample has temp below OT_CLEAR. A sample between the two thresholds does not clear the condition.
- R7: After a retry fault, conv_off_o stays high for exactly RETRY_CYC = CLK_FREQ_HZ/1e6 × RETRY_PERIOD_US clock cycles and then falls, unless an overtemperature condition is still present.
- R8: conv_off_o rises on the second rising clock edge after the edge that captures a tripping sample. It is still low after the first edge.
- R9: pg_pulldown_o is 0 only while the converter is running, vref_ramping_i is low and the last sample lies inside the power-good limits, both limits inclusive. It updates on the second edge after the capturing edge.
- R10: flt_pulldown_o is 1 only while an overvoltage latch or a retry wait is in progress.
- R11: A low on flt_line_i that this block is not driving itself switches the converter off two edges later, without pulling the line. Two edges after the line is released, the converter resumes.
- R12: When overvoltage and a retry fault trip on the same sample, the overvoltage latch is taken.
- R13: Dropping en_i switches off on the next edge and clears any latch. Raising it again restarts on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Converter enable request |
| vset_i | input | VW | Output voltage setpoint code |
| vref_ramping_i | input | 1 | Output reference still ramping |
| smp_valid_i | input | 1 | Sample strobe |
| vout_i | input | VW | Output voltage sample |
| iout_i | input | IW | Output current sample |
| temp_i | input | TW | Die temperature sample |
| flt_line_i | input | 1 | Level read back from the shared fault line |
| conv_off_o | output | 1 | Converter off request |
| pg_pulldown_o | output | 1 | 1 pulls the power-good line low |
| flt_pulldown_o | output | 1 | 1 pulls the shared fault line low |

## Verification
An overvoltage and an overcurrent trip can arrive in the same cycle, because one sample carries both voltage and current. The bench provokes this with a single sample that exceeds both limits. The result is judged against the rule that the latch must win: conv_off_o and flt_pulldown_o must still be high well after a retry period would have expired. An external pull on the fault line can also coincide with the block's own drive on that line. The block must ignore its own drive, and the bench checks this when a restart releases the line.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
  localparam int SCALE_FRAC = 10;
  localparam int NUM_THR    = 4;

  // threshold index: 0 ov, 1 uv, 2 pg low, 3 pg high
  function automatic int unsigned scale_k(input int idx);
    case (idx)
      0:       return 1331;
      1:       return 768;
      2:       return 922;
      default: return 1126;
    endcase
  endfunction

  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_RUN  = 3'd1,
    ST_WAIT = 3'd2,
    ST_OVL  = 3'd3,
    ST_EXT  = 3'd4
  } sup_state_e;
endpackage

// File: rtl/cfs_thresholds.sv
module cfs_thresholds
  import cfs_pkg::*;
#(
  parameter int VW       = 12,
  parameter int OV_FLOOR = 500
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [VW-1:0] vset_i,
  output logic [VW:0]   ov_thr_o,
  output logic [VW:0]   uv_thr_o,
  output logic [VW:0]   pg_lo_o,
  output logic [VW:0]   pg_hi_o
);
  localparam int PW = VW + SCALE_FRAC + 1;

  logic [VW-1:0] sp_q;
  logic          upd;
  logic [VW:0]   thr_q [NUM_THR];

  assign upd = (vset_i != sp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sp_q <= '0;
    else         sp_q <= vset_i;
  end

  for (genvar g = 0; g < NUM_THR; g++) begin : g_scale
    logic [PW-1:0] prod;
    assign prod = PW'(vset_i) * PW'(scale_k(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  thr_q[g] <= '0;
      else if (upd) thr_q[g] <= (VW+1)'(prod >> SCALE_FRAC);
    end
  end

  assign ov_thr_o = (thr_q[0] < (VW+1)'(OV_FLOOR)) ? (VW+1)'(OV_FLOOR) : thr_q[0];
  assign uv_thr_o = thr_q[1];
  assign pg_lo_o  = thr_q[2];
  assign pg_hi_o  = thr_q[3];

  p_ov_floor_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ov_thr_o >= (VW+1)'(OV_FLOOR));
endmodule

// File: rtl/cfs_compare.sv
module cfs_compare #(
  parameter int VW       = 12,
  parameter int IW       = 12,
  parameter int TW       = 10,
  parameter int OC_LIM   = 2800,
  parameter int OT_TRIP  = 160,
  parameter int OT_CLEAR = 150
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          smp_valid_i,
  input  logic [VW-1:0] vout_i,
  input  logic [IW-1:0] iout_i,
  input  logic [TW-1:0] temp_i,
  input  logic          ramp_i,
  input  logic [VW:0]   ov_thr_i,
  input  logic [VW:0]   uv_thr_i,
  input  logic [VW:0]   pg_lo_i,
  input  logic [VW:0]   pg_hi_i,
  output logic          ov_hit_o,
  output logic          uv_hit_o,
  output logic          oc_hit_o,
  output logic          ot_hit_o,
  output logic          hot_o,
  output logic          win_o
);
  logic [VW:0] v;
  logic        t_hi, t_lo;

  assign v    = {1'b0, vout_i};
  assign t_hi = temp_i >= TW'(OT_TRIP);
  assign t_lo = temp_i <  TW'(OT_CLEAR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ov_hit_o <= 1'b0;
      uv_hit_o <= 1'b0;
      oc_hit_o <= 1'b0;
      ot_hit_o <= 1'b0;
      hot_o    <= 1'b0;
      win_o    <= 1'b0;
    end else begin
      ov_hit_o <= smp_valid_i && (v > ov_thr_i);
      uv_hit_o <= smp_valid_i && !ramp_i && (v < uv_thr_i);
      oc_hit_o <= smp_valid_i && (iout_i > IW'(OC_LIM));
      ot_hit_o <= smp_valid_i && t_hi;
      if (smp_valid_i) begin
        win_o <= (v >= pg_lo_i) && (v <= pg_hi_i);
        if (t_hi)      hot_o <= 1'b1;
        else if (t_lo) hot_o <= 1'b0;
      end
    end
  end

  p_uv_mask_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && ramp_i) |=> !uv_hit_o);
  p_hot_hyst_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hot_o && !(smp_valid_i && t_lo)) |=> hot_o);
endmodule

// File: rtl/cfs_retry_timer.sv
module cfs_retry_timer #(
  parameter int RETRY_CYC = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = (RETRY_CYC > 1) ? $clog2(RETRY_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(RETRY_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign done_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (!done_o) cnt_q <= cnt_q + 1'b1;
  end

  p_cnt_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/conv_fault_supervisor.sv
module conv_fault_supervisor
  import cfs_pkg::*;
#(
  parameter int VW              = 12,
  parameter int IW              = 12,
  parameter int TW              = 10,
  parameter int RATED_I         = 2000,
  parameter int OV_FLOOR        = 500,
  parameter int OT_TRIP         = 160,
  parameter int OT_CLEAR        = 150,
  parameter int CLK_FREQ_HZ     = 250_000_000,
  parameter int RETRY_PERIOD_US = 130_000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [VW-1:0] vset_i,
  input  logic          vref_ramping_i,
  input  logic          smp_valid_i,
  input  logic [VW-1:0] vout_i,
  input  logic [IW-1:0] iout_i,
  input  logic [TW-1:0] temp_i,
  input  logic          flt_line_i,
  output logic          conv_off_o,
  output logic          pg_pulldown_o,
  output logic          flt_pulldown_o
);
  localparam int OC_LIM    = RATED_I * 140 / 100;
  localparam int RETRY_CYC = (CLK_FREQ_HZ / 1_000_000) * RETRY_PERIOD_US;

  logic [VW:0] ov_thr, uv_thr, pg_lo, pg_hi;
  logic        ov_hit, uv_hit, oc_hit, ot_hit, hot, win;
  logic        tmr_done;
  logic        ext_low_q, ramp_q, pg_pd_q;
  sup_state_e  state_q, state_d;

  cfs_thresholds #(.VW(VW), .OV_FLOOR(OV_FLOOR)) u_thr (
    .clk_i, .rst_ni, .vset_i,
    .ov_thr_o(ov_thr), .uv_thr_o(uv_thr), .pg_lo_o(pg_lo), .pg_hi_o(pg_hi)
  );

  cfs_compare #(
    .VW(VW), .IW(IW), .TW(TW), .OC_LIM(OC_LIM),
    .OT_TRIP(OT_TRIP), .OT_CLEAR(OT_CLEAR)
  ) u_cmp (
    .clk_i, .rst_ni, .smp_valid_i, .vout_i, .iout_i, .temp_i,
    .ramp_i(vref_ramping_i),
    .ov_thr_i(ov_thr), .uv_thr_i(uv_thr), .pg_lo_i(pg_lo), .pg_hi_i(pg_hi),
    .ov_hit_o(ov_hit), .uv_hit_o(uv_hit), .oc_hit_o(oc_hit), .ot_hit_o(ot_hit),
    .hot_o(hot), .win_o(win)
  );

  cfs_retry_timer #(.RETRY_CYC(RETRY_CYC)) u_tmr (
    .clk_i, .rst_ni,
    .run_i(state_q == ST_WAIT),
    .done_o(tmr_done)
  );

  always_comb begin
    state_d = state_q;
    if (!en_i) state_d = ST_OFF;
    else begin
      unique case (state_q)
        ST_OFF:  state_d = ST_RUN;
        ST_RUN: begin
          if (ov_hit)                         state_d = ST_OVL;
          else if (uv_hit || oc_hit || ot_hit) state_d = ST_WAIT;
          else if (ext_low_q)                 state_d = ST_EXT;
        end
        ST_WAIT: if (tmr_done && !hot) state_d = ST_RUN;
        ST_OVL:  state_d = ST_OVL;
        ST_EXT:  if (!ext_low_q) state_d = ST_RUN;
        default: state_d = ST_OFF;
      endcase
    end
  end

  assign flt_pulldown_o = (state_q == ST_OVL) || (state_q == ST_WAIT);
  assign conv_off_o     = (state_q != ST_RUN);
  assign pg_pulldown_o  = pg_pd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_OFF;
      ext_low_q <= 1'b0;
      ramp_q    <= 1'b1;
      pg_pd_q   <= 1'b1;
    end else begin
      state_q   <= state_d;
      // own drive on the wired-AND line is not an external request
      ext_low_q <= !flt_line_i && !flt_pulldown_o;
      ramp_q    <= vref_ramping_i;
      pg_pd_q   <= !((state_q == ST_RUN) && win && !ramp_q);
    end
  end

  p_ovl_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OVL && en_i) |=> (state_q == ST_OVL));
  p_wait_early_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && en_i && !tmr_done) |=> (state_q == ST_WAIT));
  p_hot_blocks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && hot) |=> conv_off_o);
  p_flt_needs_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flt_pulldown_o |-> conv_off_o);
  p_pg_when_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_off_o |=> pg_pulldown_o);
  p_ov_first_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && en_i && ov_hit) |=> (state_q == ST_OVL));
endmodule

// File: tb/sim_conv_fault_supervisor.sv
`timescale 1ns/1ps
module sim_conv_fault_supervisor;
  localparam int VW = 12, IW = 12, TW = 10;
  localparam int RETRY = 40;

  typedef struct {
    int    at;
    bit    off;
    bit    pg;
    bit    flt;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [VW-1:0] vset = 12'd1000;
  logic ramp = 1'b1;
  logic valid = 1'b0;
  logic [VW-1:0] vout = '0;
  logic [IW-1:0] iout = '0;
  logic [TW-1:0] temp = '0;
  logic ext_pull = 1'b0;
  logic conv_off, pg_pd, flt_pd;
  logic flt_line;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  exp_t q[$];

  assign flt_line = !(flt_pd || ext_pull);

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  conv_fault_supervisor #(
    .VW(VW), .IW(IW), .TW(TW), .RATED_I(1000), .OV_FLOOR(500),
    .OT_TRIP(160), .OT_CLEAR(150), .CLK_FREQ_HZ(1_000_000),
    .RETRY_PERIOD_US(RETRY)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .vset_i(vset),
    .vref_ramping_i(ramp), .smp_valid_i(valid), .vout_i(vout),
    .iout_i(iout), .temp_i(temp), .flt_line_i(flt_line),
    .conv_off_o(conv_off), .pg_pulldown_o(pg_pd), .flt_pulldown_o(flt_pd)
  );

  task automatic expect_in(input int n, input bit off, input bit pg,
                           input bit flt, input string tag);
    exp_t e;
    int pos;
    e.at = cyc + n; e.off = off; e.pg = pg; e.flt = flt; e.tag = tag;
    pos = q.size();
    while (pos > 0 && q[pos-1].at > e.at) pos--;
    q.insert(pos, e);
  endtask

  task automatic smp(input int v, input int i, input int t);
    vout = VW'(v); iout = IW'(i); temp = TW'(t); valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops expected items as their cycle comes up
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0 && q[0].at <= cyc) begin
        exp_t e;
        e = q.pop_front();
        n_chk++;
        if (conv_off !== e.off || pg_pd !== e.pg || flt_pd !== e.flt) begin
          n_bad++;
          $display("FAIL %s: off/pg/flt actual %b%b%b expected %b%b%b",
                   e.tag, conv_off, pg_pd, flt_pd, e.off, e.pg, e.flt);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    expect_in(1, 1, 1, 0, "R1 reset state");
    idle(3);

    // R4 masked during ramp
    en = 1'b1; idle(2);
    smp(500, 500, 100);
    expect_in(1, 0, 1, 0, "R4 uv masked while ramping");
    idle(3);

    // R9 power-good window
    ramp = 1'b0; idle(2);
    smp(1000, 500, 100); expect_in(1, 0, 0, 0, "R9 inside window"); idle(2);
    smp(1100, 500, 100); expect_in(1, 0, 1, 0, "R9 above high limit"); idle(2);
    smp(1099, 500, 100); expect_in(1, 0, 0, 0, "R9 at high limit"); idle(2);
    smp(900, 500, 100);  expect_in(1, 0, 0, 0, "R9 at low limit"); idle(2);
    smp(899, 500, 100);  expect_in(1, 0, 1, 0, "R9 below low limit"); idle(2);
    smp(1000, 500, 100); idle(2);

    // R5 overcurrent, R7 retry, R8 latency
    smp(1000, 1400, 100); expect_in(1, 0, 0, 0, "R5 at limit no trip"); idle(2);
    expect_in(1, 0, 0, 0, "R8 not off after first edge");
    smp(1000, 1401, 100);
    expect_in(1, 1, 0, 1, "R8 off after second edge");
    expect_in(RETRY, 1, 1, 1, "R7 still off at end of period");
    expect_in(RETRY + 1, 0, 1, 0, "R7 restart after period");
    idle(RETRY + 3);
    smp(1000, 500, 100); idle(2);

    // R4 undervoltage
    smp(750, 500, 100); expect_in(1, 0, 1, 0, "R4 at threshold no trip"); idle(2);
    smp(749, 500, 100);
    expect_in(1, 1, 1, 1, "R4 uv trip");
    expect_in(RETRY, 1, 1, 1, "R4 R7 off during wait");
    expect_in(RETRY + 1, 0, 1, 0, "R4 retry restart");
    idle(RETRY + 3);
    smp(1000, 500, 100); idle(2);

    // R6 overtemperature hysteresis
    smp(1000, 500, 159); expect_in(1, 0, 0, 0, "R6 below trip"); idle(2);
    smp(1000, 500, 160); expect_in(1, 1, 0, 1, "R6 ot trip"); idle(5);
    smp(1000, 500, 155); idle(RETRY + 5);
    expect_in(1, 1, 1, 1, "R6 hot holds off past period"); idle(2);
    smp(1000, 500, 149); expect_in(1, 0, 1, 0, "R6 restart after cooling");
    idle(3);
    smp(1000, 500, 100); idle(2);

    // R2 / R3 overvoltage latch, R13 enable
    smp(1299, 500, 100); expect_in(1, 0, 1, 0, "R2 at ov threshold no trip"); idle(2);
    smp(1300, 500, 100);
    expect_in(1, 1, 1, 1, "R3 ov latch");
    expect_in(2 * RETRY, 1, 1, 1, "R3 latch holds past period");
    idle(2 * RETRY + 2);
    en = 1'b0; expect_in(1, 1, 1, 0, "R13 disable clears latch"); idle(2);
    en = 1'b1; expect_in(1, 0, 1, 0, "R13 reenable restarts"); idle(2);

    // R2 floor
    vset = 12'd300; idle(3);
    smp(450, 500, 100); expect_in(1, 0, 1, 0, "R2 floor no trip"); idle(2);
    smp(501, 500, 100); expect_in(1, 1, 1, 1, "R2 floor trip"); idle(2);
    en = 1'b0; idle(2); en = 1'b1; vset = 12'd1000; idle(3);
    smp(1000, 500, 100); idle(2);

    // R11 external shutdown
    ext_pull = 1'b1;
    expect_in(2, 1, 0, 0, "R11 external low forces off"); idle(5);
    expect_in(1, 1, 1, 0, "R11 held off, line not driven"); idle(2);
    ext_pull = 1'b0;
    expect_in(2, 0, 1, 0, "R11 resume after release"); idle(4);
    smp(1000, 500, 100); idle(2);

    // R12 ov and oc on one sample
    smp(1300, 1500, 100);
    expect_in(1, 1, 1, 1, "R12 ov wins");
    expect_in(RETRY + 5, 1, 1, 1, "R12 latched not retried");
    idle(RETRY + 7);
    en = 1'b0; idle(2); en = 1'b1; idle(2);
    smp(1000, 500, 100);
    expect_in(1, 0, 0, 0, "R13 normal after final reenable");
    idle(4);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule